// File: doc/BRIEF.md
# Descriptor-Driven SPI Command Engine

This block is a SPI host that runs a whole bus transaction from a command descriptor held in local memory. Software programs a descriptor base address and a receive base address for one of two channels, then starts the channel through an 8-bit register port. The engine fetches the descriptor over a byte-wide memory port, shifts out up to 16 inline command bytes, and then runs a data phase. In a write, extra bytes are read from a memory block and sent. In a read, bytes are received and written back to memory at the channel's receive address. At the end it raises a bus-end status bit and an interrupt, and it either releases chip select or holds it for a following descriptor.

The memory port is a request/grant stream. The engine raises `mem_req` with `mem_addr`, `mem_we` and `mem_wdata`, and holds all four unchanged until a cycle in which `mem_gnt` is high; that cycle completes the handshake. A granted read returns its byte with `mem_rvalid` on any later cycle, and only one read is outstanding at a time. The memory may stall for any number of cycles. The serial clock runs one half period per `sck_tick` pulse from an external clock generator. The bus runs in mode 0 with single-line 8-bit words.

Top module: `spi_desc_engine`

## Requirements
- R1: Writing register 0x00 with bit0=1 and a channel select bit (bit1 = channel 0, bit2 = channel 1, channel 0 wins if both are set) while idle starts a transaction. `busy` (also register 0x01 bit7) reads 1 from the next cycle until the transaction completes.
- R2: Descriptor layout, by byte offset from the descriptor base:
  - 0: inline count; values above 16 act as 16.
  - 1: command; bit1 = read, bit3 = keep chip select; other bits are ignored.
  - 2 and 3: data length, low byte first.
  - 4 and 5: data address bits 15:0, low byte first.
  - 6: bits 1:0 give data address bits 17:16.
  - 8 onward: inline bytes.
- R3: Inline bytes go out first, MSB first, in mode 0. SCK idles low. MOSI is set up before each rising edge and MISO is sampled on the rising edge. SCK changes only on `sck_tick`.
- R4: In a write with data length N>0, N bytes are fetched from the 18-bit data address plus k (k=0..N-1) and sent after the inline bytes.
- R5: In a read with data length N>0, N bytes are received after the inline bytes while MOSI sends zeros. Byte k is written to memory at the channel's receive address plus k.
- R6: When the data length is zero, no data phase takes place.
- R7: The chip select of the started channel (`spi_cs_n[ch]`, active low) is asserted from the start and every other chip select is high. At completion all chip selects go high, unless the keep bit is set; then the started channel stays asserted.
- R8: Completion sets status bit0 (register 0x01). Writing 1 to bit0 clears it. Status bit4 is a plain read/write mask, and `irq` = bit0 AND NOT bit4.
- R9: A start request written while busy is ignored.
- R10: A memory request holds its address, direction and write data until it is granted.
- R11: After reset, all chip selects are high, SCK is low, `irq` and `busy` are 0, and registers read 0.
- R12: The channel registers read back what was written. Channel c at base 0x08+8c holds the descriptor address bytes low, mid and high at +0, +1, +2, and the receive address bytes at +4, +5, +6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_gnt | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| sck_tick | input | 1 | Half-period enable from the clock generator |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 2 | Active-low chip selects, one per channel |
| irq | output | 1 | Bus-end interrupt |
| busy | output | 1 | Transaction in progress |

## Verification
Assertions check the following on every cycle:
- a stalled memory request stays stable;
- SCK moves only on a tick;
- MOSI changes only on a load or a falling shift;
- at most one chip select is low;
- completion always sets the bus-end bit.

Directed scenarios cover what needs a full transaction to show. They check byte order and content on the wire, the 18-bit data address for transmit data, and receive write-back at the right addresses. They also cover clamping of the inline count, chip select held by the keep bit, a start ignored while busy, and the clear and mask behaviour of the status bits.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_HREQ, S_HWAIT, S_NEXT, S_FREQ, S_FWAIT, S_SHIFT, S_WREQ, S_DONE
  } seq_st_t;
  localparam int HDR_BYTES = 8;
endpackage

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic [7:0] sh;
  logic [2:0] cnt;
  logic       active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; active <= 1'b0; sck <= 1'b0; done <= 1'b0; rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        sh <= tx_byte; cnt <= '0; sck <= 1'b0; active <= 1'b1;
      end else if (active && tick) begin
        if (!sck) begin
          sck <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (cnt == 3'd7) begin
            active <= 1'b0; done <= 1'b1;
          end else begin
            sh <= {sh[6:0], 1'b0}; cnt <= cnt + 3'd1;
          end
        end
      end
    end
  end

  assign mosi = sh[7];

  // R3
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !go) |=> $stable(sck));
  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !(tick && sck)) |=> $stable(mosi));
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq import spi_eng_pkg::*; #(
  parameter int AW = 24,
  parameter int NCH = 2,
  parameter int MAX_INLINE = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] ch,
  input  logic [AW-1:0] desc_base,
  input  logic [AW-1:0] rx_base,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_rvalid,
  input  logic [7:0]    mem_rdata,
  output logic          sh_go,
  output logic [7:0]    sh_tx,
  input  logic          sh_done,
  input  logic [7:0]    sh_rx,
  output logic [NCH-1:0] cs_n,
  output logic          busy,
  output logic          done
);
  seq_st_t st;
  logic [AW-1:0] d_base, r_base;
  logic [2:0]  hidx;
  logic [7:0]  cnt, inl_idx, inl_cnt;
  logic [15:0] len, dat_idx;
  logic [17:0] daddr;
  logic        is_rd, keep, inl_phase, dat_left;

  assign inl_cnt   = (cnt > 8'(MAX_INLINE)) ? 8'(MAX_INLINE) : cnt;
  assign inl_phase = inl_idx < inl_cnt;
  assign dat_left  = dat_idx < len;

  always_comb begin
    mem_addr = '0;
    case (st)
      S_HREQ: mem_addr = d_base + AW'(hidx);
      S_FREQ: mem_addr = inl_phase ? d_base + AW'(HDR_BYTES) + AW'(inl_idx)
                                   : AW'(daddr) + AW'(dat_idx);
      S_WREQ: mem_addr = r_base + AW'(dat_idx);
      default: mem_addr = '0;
    endcase
  end
  assign mem_req   = (st == S_HREQ) || (st == S_FREQ) || (st == S_WREQ);
  assign mem_we    = (st == S_WREQ);
  assign mem_wdata = (st == S_WREQ) ? sh_rx : 8'h00;
  assign sh_go = (st == S_FWAIT && mem_rvalid) ||
                 (st == S_NEXT && !inl_phase && dat_left && is_rd);
  assign sh_tx = (st == S_FWAIT) ? mem_rdata : 8'h00;
  assign busy  = (st != S_IDLE);
  assign done  = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; d_base <= '0; r_base <= '0; hidx <= '0; cnt <= '0;
      inl_idx <= '0; len <= '0; dat_idx <= '0; daddr <= '0;
      is_rd <= 1'b0; keep <= 1'b0; cs_n <= '1;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          d_base <= desc_base; r_base <= rx_base; hidx <= '0;
          inl_idx <= '0; dat_idx <= '0;
          cs_n <= ~(NCH'(1) << ch);
          st <= S_HREQ;
        end
        S_HREQ: if (mem_gnt) st <= S_HWAIT;
        S_HWAIT: if (mem_rvalid) begin
          case (hidx)
            3'd0: cnt <= mem_rdata;
            3'd1: begin is_rd <= mem_rdata[1]; keep <= mem_rdata[3]; end
            3'd2: len[7:0] <= mem_rdata;
            3'd3: len[15:8] <= mem_rdata;
            3'd4: daddr[7:0] <= mem_rdata;
            3'd5: daddr[15:8] <= mem_rdata;
            3'd6: daddr[17:16] <= mem_rdata[1:0];
            default: ;
          endcase
          hidx <= hidx + 3'd1;
          st <= (hidx == 3'(HDR_BYTES - 1)) ? S_NEXT : S_HREQ;
        end
        S_NEXT: begin
          if (inl_phase) st <= S_FREQ;
          else if (dat_left) st <= is_rd ? S_SHIFT : S_FREQ;
          else st <= S_DONE;
        end
        S_FREQ:  if (mem_gnt) st <= S_FWAIT;
        S_FWAIT: if (mem_rvalid) st <= S_SHIFT;
        S_SHIFT: if (sh_done) begin
          if (inl_phase) begin inl_idx <= inl_idx + 8'd1; st <= S_NEXT; end
          else if (is_rd) st <= S_WREQ;
          else begin dat_idx <= dat_idx + 16'd1; st <= S_NEXT; end
        end
        S_WREQ: if (mem_gnt) begin dat_idx <= dat_idx + 16'd1; st <= S_NEXT; end
        S_DONE: begin
          if (!keep) cs_n <= '1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R7
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
endmodule

// File: rtl/spi_desc_engine.sv
module spi_desc_engine import spi_eng_pkg::*; #(
  parameter int AW = 24,
  parameter int NCH = 2,
  parameter int MAX_INLINE = 16,
  parameter int RA = 6,
  localparam int CW = $clog2(NCH),
  localparam int NB = AW / 8,
  localparam int CH_BASE = 8,
  localparam int CH_STRIDE = 8,
  localparam int RX_OFS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [RA-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_rvalid,
  input  logic [7:0]    mem_rdata,
  input  logic          sck_tick,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic [NCH-1:0] spi_cs_n,
  output logic          irq,
  output logic          busy
);
  localparam logic [RA-1:0] A_CTRL = RA'(0);
  localparam logic [RA-1:0] A_STAT = RA'(1);

  logic [7:0]    ctrl_q;
  logic          stat_end, stat_mask, seq_done, sh_go, sh_done, start;
  logic [7:0]    sh_tx, sh_rx;
  logic [CW-1:0] st_ch;
  logic [AW-1:0] desc_addr [NCH];
  logic [AW-1:0] rx_addr   [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [AW-1:0] d_q, r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0; r_q <= '0;
      end else if (reg_we) begin
        for (int b = 0; b < NB; b++) begin
          if (reg_addr == RA'(CH_BASE + CH_STRIDE * c + b)) d_q[8*b +: 8] <= reg_wdata;
          if (reg_addr == RA'(CH_BASE + CH_STRIDE * c + RX_OFS + b)) r_q[8*b +: 8] <= reg_wdata;
        end
      end
    end
    assign desc_addr[c] = d_q;
    assign rx_addr[c]   = r_q;
  end

  always_comb begin
    st_ch = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (reg_wdata[c+1]) st_ch = CW'(c);
  end
  assign start = reg_we && (reg_addr == A_CTRL) && reg_wdata[0] &&
                 (|reg_wdata[NCH:1]) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; stat_end <= 1'b0; stat_mask <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CTRL) ctrl_q <= reg_wdata;
      if (reg_we && reg_addr == A_STAT) begin
        stat_mask <= reg_wdata[4];
        if (reg_wdata[0]) stat_end <= 1'b0;
      end
      if (seq_done) stat_end <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == A_CTRL) reg_rdata = ctrl_q;
    if (reg_addr == A_STAT) reg_rdata = {busy, 2'b00, stat_mask, 3'b000, stat_end};
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < NB; b++) begin
        if (reg_addr == RA'(CH_BASE + CH_STRIDE * c + b)) reg_rdata = desc_addr[c][8*b +: 8];
        if (reg_addr == RA'(CH_BASE + CH_STRIDE * c + RX_OFS + b)) reg_rdata = rx_addr[c][8*b +: 8];
      end
  end

  assign irq = stat_end && !stat_mask;

  spi_eng_seq #(.AW(AW), .NCH(NCH), .MAX_INLINE(MAX_INLINE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ch(st_ch),
    .desc_base(desc_addr[st_ch]), .rx_base(rx_addr[st_ch]),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .sh_go(sh_go), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx),
    .cs_n(spi_cs_n), .busy(busy), .done(seq_done));

  spi_eng_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(sck_tick), .go(sh_go), .tx_byte(sh_tx),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .done(sh_done), .rx_byte(sh_rx));

  // R8
  end_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> stat_end);
endmodule

// File: tb/spi_desc_engine_test.sv
`timescale 1ns/1ps
module spi_desc_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic mem_req, mem_gnt, mem_we;
  logic [23:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_rvalid = 1'b0;
  logic [7:0] mem_rdata = '0;
  logic sck_tick, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;
  logic [1:0] spi_cs_n;
  logic irq, busy;

  int errors = 0, checks = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_desc_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .sck_tick(sck_tick), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .irq(irq), .busy(busy));

  // memory model: 4096 bytes indexed by address bits 17:16 and 9:0
  logic [7:0] mem [4096];
  logic [1:0] gcnt = '0;
  logic [1:0] tcnt = '0;
  function automatic int mi(input logic [23:0] a);
    return int'({a[17:16], a[9:0]});
  endfunction
  assign mem_gnt  = mem_req && (gcnt != 2'd0);
  assign sck_tick = tcnt[0];
  always @(posedge clk) begin
    gcnt <= gcnt + 2'd1;
    tcnt <= tcnt + 2'd1;
    mem_rvalid <= mem_req && mem_gnt && !mem_we;
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mi(mem_addr)] <= mem_wdata;
      else mem_rdata <= mem[mi(mem_addr)];
    end
  end

  // SPI device model, mode 0; reply byte k is A0+k
  logic [7:0] txlog [64];
  int txn = 0, sbit = 0, sbyte = 0;
  logic [7:0] scap = '0;
  function automatic logic [7:0] reply(input int k);
    return 8'hA0 + 8'(k);
  endfunction
  always @(posedge spi_sck) begin
    scap = {scap[6:0], spi_mosi};
    sbit = sbit + 1;
    if (sbit == 8) begin
      if (txn < 64) txlog[txn] = scap;
      txn = txn + 1; sbit = 0; sbyte = sbyte + 1;
    end
  end
  always @(negedge spi_sck) begin
    spi_miso = reply(sbyte)[7 - sbit];
  end

  task automatic slv_clear();
    txn = 0; sbit = 0; sbyte = 0;
    spi_miso = reply(0)[7];
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 6'(a);
    #1 d = reg_rdata;
  endtask

  task automatic set_ch(input int c, input int dbase, input int rbase);
    for (int b = 0; b < 3; b++) begin
      wr(8 + 8*c + b, (dbase >> (8*b)) & 8'hFF);
      wr(8 + 8*c + 4 + b, (rbase >> (8*b)) & 8'hFF);
    end
  endtask

  task automatic put_desc(input int base, input int cnt, input int cmd, input int len,
                          input int daddr, input int ninl);
    mem[mi(24'(base))]     = 8'(cnt);
    mem[mi(24'(base + 1))] = 8'(cmd);
    mem[mi(24'(base + 2))] = 8'(len);
    mem[mi(24'(base + 3))] = 8'(len >> 8);
    mem[mi(24'(base + 4))] = 8'(daddr);
    mem[mi(24'(base + 5))] = 8'(daddr >> 8);
    mem[mi(24'(base + 6))] = 8'(daddr >> 16);
    mem[mi(24'(base + 7))] = 8'h00;
    for (int i = 0; i < ninl; i++) mem[mi(24'(base + 8 + i))] = 8'h10 + 8'(i);
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d);
    chk(d == 8'h00, "R11 ctrl reset", d, 0);
    rd(1, d);
    chk(d == 8'h00, "R11 status reset", d, 0);
    chk(spi_cs_n == 2'b11 && !spi_sck && !irq && !busy, "R11 pins reset",
        {spi_cs_n, spi_sck, irq, busy}, 8'h18);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    set_ch(1, 24'h123456, 24'hABCDEF);
    rd(8 + 8 + 1, d);
    chk(d == 8'h34, "R12 ch1 desc mid", d, 8'h34);
    rd(8 + 8 + 4 + 2, d);
    chk(d == 8'hAB, "R12 ch1 rx high", d, 8'hAB);
  endtask

  task automatic t_inline();
    logic [7:0] d;
    slv_clear();
    put_desc(24'h100, 3, 8'h01, 0, 0, 3);
    set_ch(0, 24'h100, 0);
    wr(0, 8'h03);
    #1;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    chk(spi_cs_n == 2'b10, "R7 cs0 asserted", spi_cs_n, 2'b10);
    wait_idle();
    chk(txn == 3, "R6 inline only byte count", txn, 3);
    for (int i = 0; i < 3; i++)
      chk(txlog[i] == 8'h10 + 8'(i), "R3 inline byte", txlog[i], 8'h10 + i);
    chk(spi_cs_n == 2'b11, "R7 cs released", spi_cs_n, 2'b11);
    rd(1, d);
    chk(d == 8'h01, "R8 bus end set", d, 1);
    chk(irq == 1'b1, "R8 irq raised", irq, 1);
    wr(1, 8'h01);
    rd(1, d);
    chk(d == 8'h00 && !irq, "R8 write one clears", d, 0);
  endtask

  task automatic t_wdata();
    slv_clear();
    put_desc(24'h200, 2, 8'h01, 4, 24'h020300, 2);
    for (int k = 0; k < 4; k++) begin
      mem[mi(24'h020300 + 24'(k))] = 8'h50 + 8'(k);
      mem[mi(24'h000300 + 24'(k))] = 8'hEE;
    end
    set_ch(0, 24'h200, 0);
    wr(0, 8'h03);
    wait_idle();
    chk(txn == 6, "R4 write byte count", txn, 6);
    chk(txlog[0] == 8'h10 && txlog[1] == 8'h11, "R4 inline first", {txlog[0], txlog[1]}, 16'h1011);
    for (int k = 0; k < 4; k++)
      chk(txlog[2+k] == 8'h50 + 8'(k), "R4 R10 data byte from 18-bit address",
          txlog[2+k], 8'h50 + k);
  endtask

  task automatic t_read();
    slv_clear();
    put_desc(24'h080, 1, 8'h0B, 3, 0, 1);
    for (int k = 0; k < 3; k++) mem[mi(24'h000180 + 24'(k))] = 8'h00;
    set_ch(1, 24'h080, 24'h000180);
    wr(0, 8'h05);
    #1;
    chk(spi_cs_n == 2'b01, "R7 cs1 asserted", spi_cs_n, 2'b01);
    wait_idle();
    chk(txn == 4 && txlog[0] == 8'h10, "R5 inline then receive", txn, 4);
    chk(txlog[1] == 8'h00 && txlog[3] == 8'h00, "R5 zeros on mosi", txlog[1], 0);
    for (int k = 0; k < 3; k++)
      chk(mem[mi(24'h000180 + 24'(k))] == 8'hA1 + 8'(k), "R5 write-back",
          mem[mi(24'h000180 + 24'(k))], 8'hA1 + k);
    chk(spi_cs_n == 2'b01, "R7 keep holds cs1", spi_cs_n, 2'b01);
  endtask

  task automatic t_clamp();
    slv_clear();
    put_desc(24'h300, 20, 8'h01, 0, 0, 20);
    set_ch(0, 24'h300, 0);
    wr(0, 8'h03);
    wait_idle();
    chk(txn == 16, "R2 inline count clamped", txn, 16);
    chk(txlog[15] == 8'h1F, "R2 last inline byte", txlog[15], 8'h1F);
    chk(spi_cs_n == 2'b11, "R7 all released", spi_cs_n, 2'b11);
  endtask

  task automatic t_busy();
    wr(1, 8'h01);
    slv_clear();
    set_ch(0, 24'h100, 0);
    wr(0, 8'h03);
    repeat (10) @(negedge clk);
    wr(0, 8'h05);
    wait_idle();
    repeat (200) @(negedge clk);
    chk(txn == 3, "R9 second start ignored", txn, 3);
    chk(spi_cs_n == 2'b11 && !busy, "R9 channel 1 never started", spi_cs_n, 2'b11);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(1, 8'h10);
    rd(1, d);
    chk(d == 8'h11, "R8 mask set, end kept", d, 8'h11);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    wr(1, 8'h01);
    rd(1, d);
    chk(d == 8'h00, "R8 cleared", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_inline();
    t_wdata();
    t_read();
    t_clamp();
    t_busy();
    t_mask();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule